// File: doc/BRIEF.md
# Saturating-Count Push-Button Debouncer

This block turns the raw, bouncing level of a mechanical push-button into a clean "pressed" indication. The raw level first crosses into the clock domain through a two-stage synchronizer. A counter then runs while the synchronized level is high. Any low sample returns it to zero. Once the count has run long enough to cover the contact settling interval, the pressed output is raised. The count then holds at that value and does not wrap.

The settling limit is computed from two parameters: the clock rate in kHz and the settle time in ms. With the defaults of 50,000 kHz and 5 ms the limit is 250,000 cycles, and the counter is 18 bits wide. A bench can pass small values so that the limit is a handful of cycles. Release is not filtered: the first synchronized low sample clears the count and drops the output at once.

Top module: `btn_debounce`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) clears the synchronizer, the counter and `pressed_o`. `pressed_o` is 0 after reset, and also on the edge after reset is asserted while the button is held.
- R2: The raw input passes through two flip-flops before it reaches the counter. After a steady high level begins, `pressed_o` first reads 1 exactly LIMIT+2 clock edges later, where LIMIT = CLK_KHZ × SETTLE_MS.
- R3: A synchronized low sample clears the counter. A run of high samples shorter than LIMIT therefore never raises `pressed_o`.
- R4: The counter increments on each synchronized high sample until it reaches LIMIT. It then holds at LIMIT and never exceeds it, so `pressed_o` stays high through an arbitrarily long hold.
- R5: For a run of n ≥ LIMIT high samples, `pressed_o` is high for exactly n−LIMIT+1 cycles.
- R6: `pressed_o` is registered. It falls exactly 3 clock edges after the raw input goes low: two synchronizer stages, then the edge on which the counter clears.
- R7: A single-cycle low glitch while the button is pressed drops `pressed_o` for exactly LIMIT cycles before it rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| raw_i | input | 1 | Raw, asynchronous button level, high when pressed |
| pressed_o | output | 1 | Registered, debounced pressed indication |

## Verification
Two events can land on the same edge: the counter reaching its limit, and a low sample that clears it. A run of exactly LIMIT−1 high samples makes the clear coincide with the edge that would have raised the output; a run of exactly LIMIT makes the output high for a single cycle. A sweep of run lengths from 1 to LIMIT+12 covers both boundaries. Each run is judged by the measured rise time, fall time and total high cycles, all against arithmetic on LIMIT. A mid-press glitch also tests clear and recount against each other, and a reset during a press tests reset against saturation.

// File: rtl/db_pkg.sv
package db_pkg;
  // Settling limit in cycles from clock rate (kHz) and settle time (ms)
  function automatic int unsigned settle_cycles(input int unsigned khz, input int unsigned ms);
    return khz * ms;
  endfunction

  // Bits needed to hold the values 0..lim
  function automatic int unsigned count_bits(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/db_sync.sv
module db_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/db_counter.sv
module db_counter #(
  parameter int unsigned LIMIT = 8,
  parameter int unsigned CW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          level_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_next_o
);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    if (!level_i)            cnt_nxt = '0;
    else if (cnt_q == LIM_V) cnt_nxt = cnt_q;
    else                     cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_nxt;
  end

  assign cnt_o      = cnt_q;
  assign hit_next_o = (cnt_nxt == LIM_V);

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LIM_V);

  // R3
  low_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !level_i |=> cnt_q == '0);

  // R4
  count_up_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (level_i && cnt_q != LIM_V) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R4
  saturate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (level_i && cnt_q == LIM_V) |=> cnt_q == LIM_V);
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned CLK_KHZ   = 50000,
  parameter int unsigned SETTLE_MS = 5
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic pressed_o
);
  import db_pkg::*;

  localparam int unsigned LIMIT = settle_cycles(CLK_KHZ, SETTLE_MS);
  localparam int unsigned CW    = count_bits(LIMIT);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic          sync_lvl;
  logic          hit_next;
  logic [CW-1:0] cnt_val;
  logic          pressed_q;

  db_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (raw_i),
    .q_o   (sync_lvl)
  );

  db_counter #(.LIMIT(LIMIT), .CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .level_i    (sync_lvl),
    .cnt_o      (cnt_val),
    .hit_next_o (hit_next)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) pressed_q <= 1'b0;
    else       pressed_q <= hit_next;
  end

  assign pressed_o = pressed_q;

  // R2
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rst_i) && !$past(rst_i, 2)) |-> sync_lvl == $past(raw_i, 2));

  // R5
  pressed_at_limit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    pressed_q |-> cnt_val == LIM_V);

  // R6
  low_drops_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !sync_lvl |=> !pressed_q);
endmodule

// File: tb/test_btn_debounce.sv
module test_btn_debounce;
  localparam int LIM = 8;  // CLK_KHZ=4 x SETTLE_MS=2

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw = 1'b0;
  wire  pressed;
  int   errs = 0;
  int   checks = 0;

  btn_debounce #(.CLK_KHZ(4), .SETTLE_MS(2)) i_btn_debounce (
    .clk_i(clk), .rst_i(rst), .raw_i(raw), .pressed_o(pressed)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // High for n iterations, then low; measure first/last high and count.
  task automatic run_pulse(input int n, output int first, output int last, output int cnt);
    first = -1; last = -1; cnt = 0;
    for (int i = 0; i < n + LIM + 8; i++) begin
      @(negedge clk);
      if (pressed) begin
        if (first < 0) first = i;
        last = i;
        cnt++;
      end
      raw = (i < n);
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errs++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int f, l, c, lowc, rise;
    repeat (3) @(negedge clk);
    chk(pressed == 1'b0, "R1 reset state", pressed, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(pressed == 1'b0, "R1 idle after reset", pressed, 0);

    // Sweep of run lengths
    for (int n = 1; n <= LIM + 12; n++) begin
      run_pulse(n, f, l, c);
      if (n < LIM) begin
        chk(c == 0, "R3 short run no press", c, 0);
      end else begin
        chk(f == LIM + 2, "R2 rise latency", f, LIM + 2);
        chk(c == n - LIM + 1, "R5 high cycles", c, n - LIM + 1);
        chk(l == n + 2, "R6 fall latency", l + 1, n + 3);
      end
    end

    // Long hold: saturation must keep output high
    run_pulse(LIM + 40, f, l, c);
    chk(c == 41, "R4 saturating long hold", c, 41);

    // Single-cycle glitch while pressed
    lowc = 0;
    rise = -1;
    for (int i = 0; i < 3 * LIM + 20; i++) begin
      @(negedge clk);
      if (i >= LIM + 7 && !pressed) lowc++;
      if (i > LIM + 7 && pressed && rise < 0 && lowc > 0) rise = i;
      raw = (i != LIM + 4);
    end
    chk(lowc == LIM, "R7 glitch low cycles", lowc, LIM);
    chk(rise == LIM + 7 + LIM, "R7 glitch recovery", rise, 2 * LIM + 7);

    // Reset during a press with raw held high
    @(negedge clk);
    chk(pressed == 1'b1, "R4 still pressed before reset", pressed, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(pressed == 1'b0, "R1 reset during press", pressed, 0);
    rst = 1'b0;
    rise = -1;
    for (int i = 1; i <= LIM + 6; i++) begin
      @(negedge clk);
      if (pressed && rise < 0) rise = i;
    end
    chk(rise == LIM + 2, "R1 recount after reset", rise, LIM + 2);
    raw = 1'b0;
    repeat (4) @(negedge clk);
    chk(pressed == 1'b0, "R6 released at end", pressed, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule